// File: doc/BRIEF.md
# Sleep-Aware Watchdog Timer

This block watches for a stalled processor. It counts periods of a low-frequency tick, nominally about 31 kHz. A prescaler folds those ticks into a base unit of about one millisecond. A span counter then counts base units up to a power-of-two limit. The limit comes from a period-select register that software can write. The counter must be cleared by a clear command before it reaches the limit.

A 2-bit mode input, a software enable bit and the block's own sleep state together decide whether counting is active. If the limit is reached while the device is awake, the block raises a one-cycle reset request. If it is reached while the device is asleep, it raises a one-cycle wake request and leaves sleep instead of resetting.

The block keeps two active-low status flags, one for time-out and one for power-down. Several events hold the counter at zero: a clear command, entering or leaving sleep, an oscillator failure, a busy start-up timer, and being disabled. The start-up timer is only busy after wake with a crystal-type clock source, so with other clock sources the counter resumes at once.

Top module: `wdt_guard`

## Requirements
- R1: After reset, rst_req, wake_req and asleep are 0, and to_n and pd_n are 1. The period code is DEF_EXP, so with every input idle and mode 11 the first rst_req appears TICKS_PER_MS·2^DEF_EXP ticked cycles after reset is released.
- R2: With mode 11 while awake, one clock cycle after the edge that consumes the final tick, a single-cycle rst_req is raised and to_n drops to 0. The final tick is tick TICKS_PER_MS·2^n after the last clear, where n is the period code. wake_req stays 0.
- R3: With mode 10, the counter runs while awake and is held at zero while asleep, so no request appears during sleep.
- R4: With mode 01, sw_en alone decides: 1 counts both awake and asleep, and 0 holds the counter at zero.
- R5: With mode 00, the counter is held at zero and no request is ever raised, awake or asleep.
- R6: Period codes above MAX_EXP behave exactly like MAX_EXP. The code is written through per_we/per_wdata and is 5 bits wide.
- R7: A clear command restarts the full period from zero and sets both to_n and pd_n to 1.
- R8: Entering sleep (sleep_cmd while awake) sets asleep to 1, pd_n to 0 and to_n to 1, and restarts the count. A time-out while asleep in an active mode raises a single-cycle wake_req with no rst_req, sets to_n to 0, leaves pd_n at 0 and drops asleep.
- R9: wake_evt while asleep drops asleep and restarts the count from zero.
- R10: An osc_fail pulse restarts the count from zero.
- R11: While ost_busy is 1 the counter stays at zero. Counting starts from zero on the first edge after it falls.
- R12: Only cycles with lf_tick high advance the count. Ticks on alternate cycles roughly double the time to the request.
- R13: Switching the mode to a disabled setting, even for one cycle, discards the partial count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_tick | input | 1 | One-cycle qualifier per low-frequency oscillator period |
| cfg_mode | input | 2 | Mode: 11 always, 10 awake only, 01 software, 00 off |
| sw_en | input | 1 | Software enable, used in mode 01 |
| per_we | input | 1 | Write strobe for the period code |
| per_wdata | input | 5 | Period code n, time-out 2^n base units |
| clr_cmd | input | 1 | Clear command |
| sleep_cmd | input | 1 | Request to enter sleep |
| wake_evt | input | 1 | External wake event |
| osc_fail | input | 1 | Oscillator failure detected |
| ost_busy | input | 1 | Start-up timer running |
| rst_req | output | 1 | One-cycle reset request |
| wake_req | output | 1 | One-cycle wake request |
| to_n | output | 1 | Time-out flag, active low |
| pd_n | output | 1 | Power-down flag, active low |
| asleep | output | 1 | Current sleep state |

## Verification
The period code is swept over all 32 values. Each measured interval is compared with TICKS_PER_MS·2^min(n,MAX_EXP), which separates the power-of-two decode from the saturation point.

Each mode is run both awake and asleep. Only the expected combinations may produce a request, and that request must be of the right kind (reset or wake).

Mid-period clears, osc_fail, a long ost_busy hold and a brief disabling each restart the interval. The bench checks that the interval is measured from the restart and not from the earlier clear.

Alternate-cycle ticking shows that only qualified ticks advance the count.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  typedef enum logic [1:0] {
    WG_OFF    = 2'b00,
    WG_SOFT   = 2'b01,
    WG_AWAKE  = 2'b10,
    WG_ALWAYS = 2'b11
  } wg_mode_e;

  localparam int WG_SEL_W = 5;
endpackage

// File: rtl/wdt_mode_gate.sv
module wdt_mode_gate
  import wdt_guard_pkg::*;
(
  input  logic [1:0] cfg_mode,
  input  logic       sw_en,
  input  logic       asleep,
  output logic       active
);
  wg_mode_e mode;

  always_comb begin
    mode = wg_mode_e'(cfg_mode);
    unique case (mode)
      WG_ALWAYS: active = 1'b1;
      WG_AWAKE:  active = ~asleep;
      WG_SOFT:   active = sw_en;
      default:   active = 1'b0;
    endcase
  end
endmodule

// File: rtl/wdt_base_div.sv
module wdt_base_div #(
  parameter int TICKS_PER_MS = 31,
  localparam int DW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic lf_tick,
  output logic ms_tick
);
  logic [DW-1:0] pre_q;

  assign ms_tick = lf_tick && (pre_q == DW'(TICKS_PER_MS - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)   pre_q <= '0;
    else if (ms_tick) pre_q <= '0;
    else if (lf_tick) pre_q <= pre_q + DW'(1);
  end

  // R12
  pre_range_chk: assert property (@(posedge clk) disable iff (rst)
    pre_q <= DW'(TICKS_PER_MS - 1));
endmodule

// File: rtl/wdt_span_cnt.sv
module wdt_span_cnt #(
  parameter int MAX_EXP = 18,
  parameter int SEL_W   = 5,
  localparam int CW = (MAX_EXP > 0) ? MAX_EXP : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             active,
  input  logic             ms_tick,
  input  logic [SEL_W-1:0] exp_sel,
  output logic             expire,
  output logic [CW-1:0]    cnt
);
  localparam logic [CW:0] ONE = 1;

  logic [SEL_W-1:0] eff_exp;
  logic [CW:0]      lim_m1;

  always_comb begin
    eff_exp = (exp_sel > SEL_W'(MAX_EXP)) ? SEL_W'(MAX_EXP) : exp_sel;
    lim_m1  = (ONE << eff_exp) - ONE;
    expire  = active && !clr && ms_tick && ({1'b0, cnt} >= lim_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !active || expire) cnt <= '0;
    else if (ms_tick)                    cnt <= cnt + CW'(1);
  end

  // R5
  inactive_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt == '0));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int TICKS_PER_MS = 31,
  parameter int MAX_EXP      = 18,
  parameter int DEF_EXP      = 11,
  localparam int CW = (MAX_EXP > 0) ? MAX_EXP : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lf_tick,
  input  logic [1:0]          cfg_mode,
  input  logic                sw_en,
  input  logic                per_we,
  input  logic [WG_SEL_W-1:0] per_wdata,
  input  logic                clr_cmd,
  input  logic                sleep_cmd,
  input  logic                wake_evt,
  input  logic                osc_fail,
  input  logic                ost_busy,
  output logic                rst_req,
  output logic                wake_req,
  output logic                to_n,
  output logic                pd_n,
  output logic                asleep
);
  logic [WG_SEL_W-1:0] per_q;
  logic                asleep_q, rst_req_q, wake_req_q, to_n_q, pd_n_q;
  logic                active, ms_tick, expire;
  logic                sleep_entry, sleep_exit, clr_all;
  logic [CW-1:0]       cnt;

  assign sleep_entry = sleep_cmd && !asleep_q;
  assign sleep_exit  = wake_evt && asleep_q;
  assign clr_all     = clr_cmd || sleep_entry || sleep_exit || osc_fail || ost_busy;

  wdt_mode_gate u_gate (
    .cfg_mode (cfg_mode),
    .sw_en    (sw_en),
    .asleep   (asleep_q),
    .active   (active)
  );

  wdt_base_div #(.TICKS_PER_MS(TICKS_PER_MS)) u_div (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_all || !active),
    .lf_tick (lf_tick),
    .ms_tick (ms_tick)
  );

  wdt_span_cnt #(.MAX_EXP(MAX_EXP), .SEL_W(WG_SEL_W)) u_span (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_all),
    .active  (active),
    .ms_tick (ms_tick),
    .exp_sel (per_q),
    .expire  (expire),
    .cnt     (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst)         per_q <= WG_SEL_W'(DEF_EXP);
    else if (per_we) per_q <= per_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      asleep_q   <= 1'b0;
      rst_req_q  <= 1'b0;
      wake_req_q <= 1'b0;
      to_n_q     <= 1'b1;
      pd_n_q     <= 1'b1;
    end else begin
      rst_req_q  <= expire && !asleep_q;
      wake_req_q <= expire && asleep_q;
      if (sleep_entry)                          asleep_q <= 1'b1;
      else if (asleep_q && (wake_evt || expire)) asleep_q <= 1'b0;
      if (expire)                           to_n_q <= 1'b0;
      else if (clr_cmd || sleep_entry)      to_n_q <= 1'b1;
      if (sleep_entry)  pd_n_q <= 1'b0;
      else if (clr_cmd) pd_n_q <= 1'b1;
    end
  end

  assign rst_req  = rst_req_q;
  assign wake_req = wake_req_q;
  assign to_n     = to_n_q;
  assign pd_n     = pd_n_q;
  assign asleep   = asleep_q;

  generate
    if (TICKS_PER_MS > 1) begin : g_pulse
      // R2
      rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_q |=> !rst_req_q);
    end
  endgenerate

  // R2
  rst_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_q |-> !to_n_q);

  // R8
  wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req_q |-> (!asleep_q && !to_n_q && !rst_req_q));

  // R11
  ost_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ost_busy |=> (cnt == '0));

  // R7
  clr_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_cmd && !sleep_entry) |=> (to_n_q && pd_n_q));
endmodule

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
  localparam int TPM = 2;
  localparam int MXE = 4;
  localparam int DFE = 3;
  localparam int NONE_LIM = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lf_tick = 1'b1;
  logic tick_alt = 1'b0;
  logic [1:0] cfg_mode = 2'b11;
  logic sw_en = 1'b0, per_we = 1'b0, clr_cmd = 1'b0, sleep_cmd = 1'b0;
  logic wake_evt = 1'b0, osc_fail = 1'b0, ost_busy = 1'b0;
  logic [4:0] per_wdata = '0;
  logic rst_req, wake_req, to_n, pd_n, asleep;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  always @(negedge clk) lf_tick <= tick_alt ? ~lf_tick : 1'b1;

  wdt_guard #(.TICKS_PER_MS(TPM), .MAX_EXP(MXE), .DEF_EXP(DFE)) dut_i (
    .clk(clk), .rst(rst), .lf_tick(lf_tick), .cfg_mode(cfg_mode), .sw_en(sw_en),
    .per_we(per_we), .per_wdata(per_wdata), .clr_cmd(clr_cmd),
    .sleep_cmd(sleep_cmd), .wake_evt(wake_evt), .osc_fail(osc_fail),
    .ost_busy(ost_busy), .rst_req(rst_req), .wake_req(wake_req),
    .to_n(to_n), .pd_n(pd_n), .asleep(asleep)
  );

  function automatic int span(input int n);
    return TPM * (1 << ((n > MXE) ? MXE : n));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic measure(input int lim, output int c, output int sr, output int sw);
    c = lim + 1; sr = 0; sw = 0;
    for (int i = 1; i <= lim; i++) begin
      step();
      if (rst_req || wake_req) begin
        c = i; sr = int'(rst_req); sw = int'(wake_req);
        break;
      end
    end
  endtask

  task automatic do_clr();
    clr_cmd = 1'b1; step(); clr_cmd = 1'b0;
  endtask

  task automatic set_period(input int n);
    per_we = 1'b1; per_wdata = 5'(n); clr_cmd = 1'b1;
    step();
    per_we = 1'b0; clr_cmd = 1'b0;
  endtask

  task automatic enter_sleep();
    sleep_cmd = 1'b1; step(); sleep_cmd = 1'b0;
  endtask

  task automatic wake_up();
    wake_evt = 1'b1; step(); wake_evt = 1'b0;
  endtask

  initial begin
    int c, sr, sw;
    @(negedge clk);
    repeat (3) step();
    rst = 1'b0;
    // R1 reset state
    chk("R1", "rst_req", int'(rst_req), 0);
    chk("R1", "wake_req", int'(wake_req), 0);
    chk("R1", "to_n", int'(to_n), 1);
    chk("R1", "pd_n", int'(pd_n), 1);
    chk("R1", "asleep", int'(asleep), 0);
    measure(NONE_LIM, c, sr, sw);
    chk("R1", "default interval", c, span(DFE));

    // R2 R6 sweep every period code
    for (int n = 0; n < 32; n++) begin
      set_period(n);
      measure(NONE_LIM, c, sr, sw);
      chk((n > MXE) ? "R6" : "R2", $sformatf("interval code %0d", n), c, span(n));
      chk("R2", "rst kind", sr, 1);
      chk("R2", "no wake", sw, 0);
      chk("R2", "to_n low", int'(to_n), 0);
      step();
      chk("R2", "pulse width", int'(rst_req), 0);
    end
    set_period(DFE);

    // R7 mid-period clear
    repeat (10) step();
    do_clr();
    chk("R7", "to_n set", int'(to_n), 1);
    chk("R7", "pd_n set", int'(pd_n), 1);
    measure(NONE_LIM, c, sr, sw);
    chk("R7", "interval from clear", c, span(DFE));

    // R8 sleep in mode 11
    do_clr();
    repeat (5) step();
    enter_sleep();
    chk("R8", "asleep", int'(asleep), 1);
    chk("R8", "pd_n", int'(pd_n), 0);
    chk("R8", "to_n", int'(to_n), 1);
    measure(NONE_LIM, c, sr, sw);
    chk("R8", "sleep interval", c, span(DFE));
    chk("R8", "wake kind", sw, 1);
    chk("R8", "no reset", sr, 0);
    chk("R8", "woke", int'(asleep), 0);
    chk("R8", "to_n after", int'(to_n), 0);
    chk("R8", "pd_n after", int'(pd_n), 0);
    step();
    chk("R8", "wake pulse", int'(wake_req), 0);

    // R3 mode 10
    cfg_mode = 2'b10;
    do_clr();
    enter_sleep();
    measure(NONE_LIM, c, sr, sw);
    chk("R3", "no request asleep", c, NONE_LIM + 1);
    chk("R9", "still asleep", int'(asleep), 1);
    repeat (3) step();
    wake_up();
    chk("R9", "woken by event", int'(asleep), 0);
    measure(NONE_LIM, c, sr, sw);
    chk("R9", "interval from wake", c, span(DFE));
    chk("R3", "awake reset", sr, 1);

    // R4 mode 01
    cfg_mode = 2'b01; sw_en = 1'b0;
    do_clr();
    measure(NONE_LIM, c, sr, sw);
    chk("R4", "sw_en 0 silent", c, NONE_LIM + 1);
    sw_en = 1'b1;
    do_clr();
    measure(NONE_LIM, c, sr, sw);
    chk("R4", "sw_en 1 awake", c, span(DFE));
    enter_sleep();
    measure(NONE_LIM, c, sr, sw);
    chk("R4", "sw_en 1 asleep", c, span(DFE));
    chk("R4", "asleep gives wake", sw, 1);

    // R5 mode 00
    cfg_mode = 2'b00;
    do_clr();
    measure(NONE_LIM, c, sr, sw);
    chk("R5", "off awake", c, NONE_LIM + 1);
    enter_sleep();
    measure(NONE_LIM, c, sr, sw);
    chk("R5", "off asleep", c, NONE_LIM + 1);
    wake_up();
    chk("R5", "exit sleep", int'(asleep), 0);

    // R10 oscillator failure
    cfg_mode = 2'b11;
    do_clr();
    repeat (10) step();
    osc_fail = 1'b1; step(); osc_fail = 1'b0;
    measure(NONE_LIM, c, sr, sw);
    chk("R10", "interval from osc_fail", c, span(DFE));

    // R11 start-up timer hold
    do_clr();
    ost_busy = 1'b1;
    measure(60, c, sr, sw);
    chk("R11", "held while busy", c, 61);
    ost_busy = 1'b0;
    measure(NONE_LIM, c, sr, sw);
    chk("R11", "interval after busy", c, span(DFE));

    // R13 brief disable
    do_clr();
    repeat (10) step();
    cfg_mode = 2'b00; step(); cfg_mode = 2'b11;
    measure(NONE_LIM, c, sr, sw);
    chk("R13", "interval after disable", c, span(DFE));

    // R12 alternate ticks
    tick_alt = 1'b1;
    do_clr();
    measure(NONE_LIM, c, sr, sw);
    chk("R12", "slow tick interval ok", int'(c == 2 * span(DFE) || c == 2 * span(DFE) - 1), 1);
    tick_alt = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule